// File: doc/BRIEF.md
# Two-Wire Serial Memory Target: Read Engine

This block is the target side of a two-wire serial memory bus, seen from the read path only. It oversamples the clock line (SCL) and data line (SDA) with a fast system clock and decodes bus START and STOP conditions. It acknowledges a select byte whose type nibble and chip-enable bits match its own. It then returns bytes from an internal byte array, driving SDA through an open-drain enable. A master sets the read position with a dummy write: a write-type select and two address bytes, followed by a repeated START and a read-type select. A read-type select alone resumes from the current position. Each byte the master acknowledges is followed by the next byte in order.

The internal 13-bit address counter survives STOP conditions. Any later current-address read therefore picks up where the last access ended. The array is filled through a preload port intended for test setup. Storing bytes from the bus is not part of this block. The write-control input is accepted but has no bearing on reads.

Top module: `i2c_mem_target`

## Requirements
- R1: A START (SDA falling while SCL is high) in any state releases SDA and restarts the select-byte phase. A STOP (SDA rising while SCL is high) in any state releases SDA and returns the block to idle. A transfer cut short by a STOP before the second address byte leaves the address counter unchanged.
- R2: The select byte is sent MSB first as {4'b1010, chip-enable bits 3'b, RW}. The block acknowledges it by pulling SDA low during the ninth clock only when the type nibble is 4'b1010 and the chip-enable bits equal `chip_sel`. On a mismatch SDA stays released until the next START.
- R3: After an acknowledged write-type select (RW=0), the block acknowledges two address bytes, high byte then low byte. The counter is then loaded with {high[4:0], low}, and nothing in the array changes.
- R4: After a repeated START and an acknowledged read-type select (RW=1), the block drives the byte at the loaded address, MSB first.
- R5: A read-type select with no address phase returns the byte at the current counter value, and the counter value is kept across STOP conditions.
- R6: The counter increments by one after each byte sent, and wraps from 8191 to 0.
- R7: When the master acknowledges a data byte, the next sequential byte follows. When the master does not acknowledge it, the block releases SDA and drives nothing until the next START.
- R8: The block starts pulling SDA low only while SCL is low.
- R9: The level of `wr_ctl` has no effect on any read.
- R10: The array holds 2^ARR_AW bytes (1024 by default), indexed by the low ARR_AW bits of the counter, so addresses that differ only above those bits read the same byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| chip_sel | input | 3 | Chip-enable bits expected in the select byte |
| wr_ctl | input | 1 | Write-control level, unused by reads |
| pl_we | input | 1 | Preload write strobe |
| pl_addr | input | ARR_AW | Preload array index |
| pl_data | input | 8 | Preload byte |

## Verification
On every cycle, the checker confirms several properties. A STOP returns the block to idle with SDA released, and a START reopens the select phase. Idle never drives the line, and a new pull-down begins only while SCL is low. Each counter step adds exactly one, and each address load takes the assembled address. The bench scenarios are needed for the rest: the values of the returned bytes, the acknowledge or silence for each select pattern, and counter persistence across STOP. They also cover wrap and aliasing, the sequential ack/no-ack chain, the effect of aborted transfers on the counter, and the independence from `wr_ctl`.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEL_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_HOLD,
    ST_TX,
    ST_TX_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_mem_rst_sync.sv
module i2c_mem_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic [1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) stg_q <= 2'b00;
    else          stg_q <= {stg_q[0], 1'b1};
  end

  assign rst_n_s = stg_q[1];
endmodule

// File: rtl/i2c_mem_line.sv
module i2c_mem_line #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
      sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[LAST-1];
  assign sda_s = sda_pipe[LAST-1];
  assign scl_q = scl_pipe[LAST];
  assign sda_q = sda_pipe[LAST];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_mem_addr.sv
module i2c_mem_addr #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_en,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (load_en)     addr_d = load_val;
    else if (inc_en) addr_d = addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end
endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
  parameter int ARR_AW = 10
) (
  input  logic              clk,
  input  logic              pl_we,
  input  logic [ARR_AW-1:0] pl_addr,
  input  logic [7:0]        pl_data,
  input  logic [ARR_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << ARR_AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pl_we) mem[pl_addr] <= pl_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int         ADDR_W      = 13,
  parameter int         ARR_AW      = 10,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        chip_sel,
  input  logic              wr_ctl,
  input  logic              pl_we,
  input  logic [ARR_AW-1:0] pl_addr,
  input  logic [7:0]        pl_data
);
  localparam int         HI_KEEP = ADDR_W - 8;
  localparam logic [3:0] BITS8   = 4'd8;

  logic rst_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  tgt_state_e state_q, state_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] rx_q, rx_d, tx_q, tx_d, hi_q, hi_d;
  logic       oe_q, oe_d, rd_q, rd_d, mack_q, mack_d;

  logic              addr_load, addr_inc;
  logic [ADDR_W-1:0] load_val, addr_q;
  logic [7:0]        rd_data;
  logic              sel_match;

  logic unused_ok;
  assign unused_ok = ^{wr_ctl, hi_q[7:HI_KEEP], addr_q[ADDR_W-1:ARR_AW], scl_s};

  i2c_mem_rst_sync u_rst (
    .clk(clk), .rst_n_a(rst_n), .rst_n_s(rst_s)
  );

  i2c_mem_line #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_mem_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_s), .load_en(addr_load), .load_val(load_val),
    .inc_en(addr_inc), .addr_q(addr_q)
  );

  i2c_mem_store #(.ARR_AW(ARR_AW)) u_store (
    .clk(clk), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .rd_addr(addr_q[ARR_AW-1:0]), .rd_data(rd_data)
  );

  assign load_val  = {hi_q[HI_KEEP-1:0], rx_q};
  assign sel_match = (rx_q[7:4] == DEV_TYPE) && (rx_q[3:1] == chip_sel);
  assign sda_oe    = oe_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    hi_d      = hi_q;
    oe_d      = oe_q;
    rd_d      = rd_q;
    mack_d    = mack_q;
    addr_load = 1'b0;
    addr_inc  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_SEL;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_SEL, ST_AHI, ST_ALO: begin
          if (scl_rise && cnt_q != BITS8) begin
            rx_d  = {rx_q[6:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == BITS8) begin
            if (state_q == ST_SEL) begin
              if (sel_match) begin
                oe_d    = 1'b1;
                rd_d    = rx_q[0];
                state_d = ST_SEL_ACK;
              end else begin
                state_d = ST_IDLE;
              end
            end else if (state_q == ST_AHI) begin
              hi_d    = rx_q;
              oe_d    = 1'b1;
              state_d = ST_AHI_ACK;
            end else begin
              addr_load = 1'b1;
              oe_d      = 1'b1;
              state_d   = ST_ALO_ACK;
            end
          end
        end
        ST_SEL_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rd_q) begin
              tx_d    = rd_data;
              oe_d    = ~rd_data[7];
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_AHI;
            end
          end
        end
        ST_AHI_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            cnt_d   = '0;
            state_d = ST_ALO;
          end
        end
        ST_ALO_ACK: begin
          if (scl_fall) begin
            oe_d    = 1'b0;
            state_d = ST_HOLD;
          end
        end
        ST_TX: begin
          if (scl_rise && cnt_q != BITS8) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == BITS8) begin
              oe_d     = 1'b0;
              addr_inc = 1'b1;
              state_d  = ST_TX_ACK;
            end else begin
              tx_d = {tx_q[6:0], 1'b0};
              oe_d = ~tx_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) mack_d = ~sda_s;
          if (scl_fall) begin
            if (mack_q) begin
              cnt_d   = '0;
              tx_d    = rd_data;
              oe_d    = ~rd_data[7];
              state_d = ST_TX;
            end else begin
              oe_d    = 1'b0;
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      hi_q    <= '0;
      oe_q    <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      hi_q    <= hi_d;
      oe_q    <= oe_d;
      rd_q    <= rd_d;
      mack_q  <= mack_d;
    end
  end
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_s,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_oe,
  input tgt_state_e        state_q,
  input logic              addr_inc,
  input logic              addr_load,
  input logic [ADDR_W-1:0] load_val,
  input logic [ADDR_W-1:0] addr_q
);
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_s)
    stop_det |=> (state_q == ST_IDLE && !sda_oe));

  p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_s)
    start_det |=> (state_q == ST_SEL && !sda_oe));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_IDLE) |-> !sda_oe);

  p_addr_load_r3: assert property (@(posedge clk) disable iff (!rst_s)
    addr_load |=> (addr_q == $past(load_val)));

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_s)
    addr_inc |=> (addr_q == $past(addr_q) + 1'b1));

  p_pull_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .state_q(state_q),
  .addr_inc(addr_inc), .addr_load(addr_load), .load_val(load_val),
  .addr_q(addr_q)
);

// File: tb/i2c_mem_target_tb_top.sv
`timescale 1ns/1ps
module i2c_mem_target_tb_top;
  localparam int AW = 10;
  localparam int Q  = 8;
  localparam logic [2:0] CE = 3'b101;

  logic clk = 1'b0;
  logic rst_n, scl_m, sda_m, wr_ctl, pl_we, sda_oe;
  logic [AW-1:0] pl_addr;
  logic [7:0] pl_data;
  logic sda_line;

  int n_chk = 0, n_err = 0, r8_viol = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$], act_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_target #(.ARR_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .chip_sel(CE), .wr_ctl(wr_ctl),
    .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data)
  );

  function automatic logic [7:0] pat(int a);
    int m = a % (1 << AW);
    return 8'((m * 37 + 11) ^ (m >> 2));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] v, input bit mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    send_bit(~mack);
  endtask

  task automatic exp_data(int a, string tag);
    exp_q.push_back(pat(a));
    tag_q.push_back(tag);
  endtask

  task automatic get_data(input bit mack);
    logic [7:0] v;
    recv_byte(v, mack);
    act_q.push_back(v);
  endtask

  task automatic sel(input bit rw, string tag);
    bit ack;
    send_byte({4'b1010, CE, rw}, ack);
    chk(ack, tag, "select acknowledged", ack, 1);
  endtask

  task automatic set_addr(input logic [15:0] a);
    bit ack;
    bus_start();
    sel(1'b0, "R3");
    send_byte(a[15:8], ack);
    chk(ack, "R3", "high address ack", ack, 1);
    send_byte(a[7:0], ack);
    chk(ack, "R3", "low address ack", ack, 1);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (act_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(a == e, t, "read byte", a, e);
        end else begin
          chk(1'b0, "R4", "unexpected byte", a, 0);
        end
      end
    end
  end

  // R8 observer: a new pull-down must not begin while SCL is high
  initial begin
    logic oe_prev = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && sda_oe && !oe_prev && scl_m) r8_viol++;
      oe_prev = sda_oe;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wr_ctl = 1'b0;
    pl_we = 1'b0; pl_addr = '0; pl_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sda_oe == 1'b0, "R1", "released after reset", sda_oe, 0);
    for (int i = 0; i < (1 << AW); i++) begin
      @(negedge clk);
      pl_we = 1'b1; pl_addr = AW'(i); pl_data = pat(i);
    end
    @(negedge clk);
    pl_we = 1'b0;

    // R2: wrong chip-enable bits
    bus_start();
    send_byte({4'b1010, 3'b100, 1'b1}, ack);
    chk(!ack, "R2", "no ack on chip-enable mismatch", ack, 0);
    recv_byte(v, 1'b0);
    chk(v == 8'hFF, "R2", "line released after mismatch", v, 8'hFF);
    bus_stop();

    // R2: wrong type nibble
    bus_start();
    send_byte({4'b1011, CE, 1'b1}, ack);
    chk(!ack, "R2", "no ack on type mismatch", ack, 0);
    bus_stop();

    // R3/R4: random read
    set_addr(16'h0123);
    bus_start();
    sel(1'b1, "R4");
    exp_data(16'h0123, "R4");
    get_data(1'b0);
    bus_stop();

    // R5: current read after STOP
    bus_start();
    sel(1'b1, "R5");
    exp_data(16'h0124, "R5");
    get_data(1'b0);
    bus_stop();

    // R7: sequential read with ack chain, then no-ack
    bus_start();
    sel(1'b1, "R7");
    for (int k = 0; k < 4; k++) exp_data(16'h0125 + k, "R7");
    get_data(1'b1); get_data(1'b1); get_data(1'b1); get_data(1'b0);
    begin
      int seen = 0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (sda_oe) seen++;
      end
      chk(seen == 0, "R7", "released after no-ack", seen, 0);
    end
    bus_stop();

    // R6/R3: high byte masked, wrap 8191 -> 0
    set_addr(16'hFFFF);
    bus_start();
    sel(1'b1, "R6");
    exp_data(8191, "R6"); exp_data(0, "R6"); exp_data(1, "R6");
    get_data(1'b1); get_data(1'b1); get_data(1'b0);
    bus_stop();

    // R10: aliasing above the array index bits
    set_addr(16'h0405);
    bus_start();
    sel(1'b1, "R10");
    exp_data(5, "R10");
    get_data(1'b0);
    bus_stop();

    // R9: write-control high has no effect
    wr_ctl = 1'b1;
    set_addr(16'h0050);
    bus_start();
    sel(1'b1, "R9");
    exp_data(16'h0050, "R9");
    get_data(1'b0);
    bus_stop();
    wr_ctl = 1'b0;

    // R1: STOP after the high address byte leaves the counter alone
    bus_start();
    sel(1'b0, "R1");
    send_byte(8'h07, ack);
    chk(ack, "R1", "high byte ack before abort", ack, 1);
    bus_stop();
    bus_start();
    sel(1'b1, "R1");
    exp_data(16'h0051, "R1");
    get_data(1'b0);
    bus_stop();

    // R1: START in the middle of a byte restarts the select phase
    bus_start();
    sel(1'b0, "R1");
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    sel(1'b1, "R1");
    exp_data(16'h0052, "R1");
    get_data(1'b0);
    bus_stop();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "all expected bytes seen", exp_q.size(), 0);
    chk(r8_viol == 0, "R8", "pull-down began with SCL high", r8_viol, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule